// File: doc/BRIEF.md
# Asynchronous SRAM Write Timing Monitor

This block watches the control, address and data pins of an asynchronous static RAM and reports any write that breaks the device's timing rules. It samples every pin on a fast reference clock. It measures each write-related phase in ticks of that clock and compares the result against minimum values. The minimums are given in nanoseconds as parameters and converted to ticks at elaboration time. The block is meant for simulation benches and for in-system debug next to a memory controller. It stores no memory contents and makes no judgement on read timing.

A write is taken to happen only while chip enable and write enable are both low. The window therefore opens on whichever of the two falls last and closes on whichever rises first. All address, data, pulse-width, recovery and cycle rules are measured from the edges of this overlap. Each rule has a sticky flag. A one-cycle event pulse carries the code of the rule that fired. A saturating counter totals the timing violations. A separate warning covers bus contention: the memory's output is enabled while the controller is also driving the data pins.

Top module: `sram_wr_timing_mon`

## Requirements
- R1: The write window is open in every sampled cycle where `ce_n` and `we_n` are both low. A write that respects every minimum raises no flag and no event.
- R2: If `addr` differs from its previous sample while the window was open in both that sample and the current one, rule 0 (address hold) fires. A change on the sample that opens the window is allowed.
- R3: On the sample that closes the window, rule 1 (data setup) fires if `din` has been stable for fewer than the data-setup tick count. The stable count is the number of earlier samples since its last change.
- R4: When `we_n` returns high after fewer low samples than the write-pulse tick count, rule 2 (write pulse) fires.
- R5: After the window closes, the next `addr` change must come at least the short recovery count later if `we_n` was high on the closing sample, or the long recovery count later if only `ce_n` rose. An address change on the closing sample itself always fails. A new window opening first cancels the check. Otherwise rule 3 (recovery) fires.
- R6: If a window was open at any sample since the last `addr` change, and the next change comes fewer than the cycle tick count after it, rule 4 (cycle time) fires.
- R7: Rule 5 (contention) fires once on each sample where a window is open, `oe_n` is low and `host_drv` is high, but was not all true one sample earlier. Rule 5 does not change `viol_cnt`.
- R8: The outputs are registered. One cycle after the sample, `evt_valid` is high for one cycle if any rule fired. At the same time `evt_code` holds the lowest-numbered rule that fired, and bit k of `err_flags` is set for each rule k that fired.
- R9: Flags are sticky until `clr` is sampled high, which clears all flags and `viol_cnt`. A rule firing on the same sample as `clr` still leaves its flag set and is counted.
- R10: `viol_cnt` adds, on each sample, the number of rules 0 to 4 that fired. It saturates at its maximum value.
- R11: After reset, `err_flags`, `evt_valid`, `evt_code` and `viol_cnt` are zero.
- R12: Each tick count is the smallest whole number of reference-clock periods that covers the nanosecond minimum, and is at least one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Sampled chip enable, active low |
| we_n | input | 1 | Sampled write enable, active low |
| oe_n | input | 1 | Sampled output enable, active low |
| host_drv | input | 1 | High while the controller drives the data pins |
| addr | input | ADDR_W | Sampled address bus |
| din | input | DATA_W | Sampled data bus |
| clr | input | 1 | Clears sticky flags and the violation counter |
| err_flags | output | 6 | Sticky per-rule flags, bit index equals rule code |
| evt_valid | output | 1 | One-cycle pulse when any rule fired |
| evt_code | output | 3 | Lowest-numbered rule that fired |
| viol_cnt | output | VCNT_W | Saturating count of timing violations |

## Verification
The bench uses a 10 ns reference period and a cycle minimum of 100 ns, so the tick counts become 10, 6, 3, 1 and 2. These values are small and uneven. Half-tick minimums must round up, and the pulse-width limit can be hit exactly and missed by one sample. A cycle-time failure can also be produced without breaking any other rule. The counter is built three bits wide, so a short burst of address moves inside one window drives it into saturation. A cleared-with-event sample then shows that the event wins over the clear.

// File: rtl/sram_wchk_pkg.sv
package sram_wchk_pkg;

  localparam int NUM_RULES   = 6;
  localparam int NUM_VIOL    = 5;
  localparam int CODE_W      = 3;

  // rule codes, also the bit positions of the sticky flags
  localparam int RULE_ADDR_HOLD  = 0;
  localparam int RULE_DATA_SETUP = 1;
  localparam int RULE_WE_WIDTH   = 2;
  localparam int RULE_RECOVERY   = 3;
  localparam int RULE_CYCLE      = 4;
  localparam int RULE_CONTEND    = 5;

  // nanoseconds to reference ticks, rounded up, never below one
  function automatic int ns_to_ticks(input int ns, input int tick_ps);
    int t;
    t = (ns * 1000 + tick_ps - 1) / tick_ps;
    if (t < 1) t = 1;
    return t;
  endfunction

  function automatic int max_of2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // counter width able to hold a limit and one saturation value above it
  function automatic int ctr_width(input int limit);
    return $clog2(limit + 2);
  endfunction

endpackage

// File: rtl/wchk_sampler.sv
module wchk_sampler #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              host_drv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              win_now,
  output logic              win_open,
  output logic              win_close,
  output logic              close_by_we,
  output logic              we_low,
  output logic              we_rise,
  output logic              addr_chg,
  output logic              data_chg,
  output logic              contend_onset
);

  logic              ce_q;
  logic              we_q;
  logic              cont_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  logic              win_q;
  logic              cont_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q   <= 1'b1;
      we_q   <= 1'b1;
      cont_q <= 1'b0;
      addr_q <= '0;
      din_q  <= '0;
    end else begin
      ce_q   <= ce_n;
      we_q   <= we_n;
      cont_q <= cont_now;
      addr_q <= addr;
      din_q  <= din;
    end
  end

  always_comb begin
    win_now       = ~ce_n & ~we_n;
    win_q         = ~ce_q & ~we_q;
    win_open      = win_now & ~win_q;
    win_close     = win_q & ~win_now;
    close_by_we   = win_close & we_n;
    we_low        = ~we_n;
    we_rise       = we_n & ~we_q;
    addr_chg      = (addr != addr_q);
    data_chg      = (din != din_q);
    cont_now      = win_now & ~oe_n & host_drv;
    contend_onset = cont_now & ~cont_q;
  end

  // R1: a close is seen only after both enables were low and one has risen
  a_r1_close_edge: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |-> ($past(~ce_n & ~we_n) && (ce_n || we_n)));

  // R1: an open follows a sample where at least one enable was high
  a_r1_open_edge: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> ($past(ce_n || we_n) && !ce_n && !we_n));

endmodule

// File: rtl/wchk_rules.sv
module wchk_rules
  import sram_wchk_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int WC_T  = 14,
  parameter int WP_T  = 11,
  parameter int DSU_T = 6,
  parameter int WR1_T = 1,
  parameter int WR2_T = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 win_now,
  input  logic                 win_open,
  input  logic                 win_close,
  input  logic                 close_by_we,
  input  logic                 we_low,
  input  logic                 we_rise,
  input  logic                 addr_chg,
  input  logic                 data_chg,
  input  logic                 contend_onset,
  output logic [NUM_RULES-1:0] viol
);

  localparam logic [CNT_W-1:0] LIM_WC  = CNT_W'(WC_T);
  localparam logic [CNT_W-1:0] LIM_WP  = CNT_W'(WP_T);
  localparam logic [CNT_W-1:0] LIM_DSU = CNT_W'(DSU_T);
  localparam logic [CNT_W-1:0] LIM_WR1 = CNT_W'(WR1_T);
  localparam logic [CNT_W-1:0] LIM_WR2 = CNT_W'(WR2_T);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + ONE;
  endfunction

  logic [CNT_W-1:0] data_age;   // samples since the data bus last moved
  logic [CNT_W-1:0] we_run;     // consecutive low samples of write enable
  logic [CNT_W-1:0] rec_cnt;    // ticks since the window closed
  logic [CNT_W-1:0] rec_need;   // recovery limit picked at close
  logic             rec_pend;
  logic [CNT_W-1:0] cyc_age;    // ticks since the previous address change
  logic             wrote;      // a window was seen since that change

  always_comb begin
    viol = '0;
    viol[RULE_ADDR_HOLD]  = addr_chg & win_now & ~win_open;
    viol[RULE_DATA_SETUP] = win_close & (data_age < LIM_DSU);
    viol[RULE_WE_WIDTH]   = we_rise & (we_run < LIM_WP);
    viol[RULE_RECOVERY]   = addr_chg & (win_close | (rec_pend & (rec_cnt < rec_need)));
    viol[RULE_CYCLE]      = addr_chg & wrote & (cyc_age < LIM_WC);
    viol[RULE_CONTEND]    = contend_onset;
  end

  // data stability and write-enable width
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_age <= '1;
      we_run   <= '0;
    end else begin
      data_age <= data_chg ? '0 : sat_inc(data_age);
      we_run   <= we_low ? sat_inc(we_run) : '0;
    end
  end

  // recovery after the window closes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_pend <= 1'b0;
      rec_cnt  <= '0;
      rec_need <= LIM_WR1;
    end else if (win_close && !addr_chg) begin
      rec_pend <= 1'b1;
      rec_cnt  <= ONE;
      rec_need <= close_by_we ? LIM_WR1 : LIM_WR2;
    end else if (addr_chg || win_open) begin
      rec_pend <= 1'b0;
    end else if (rec_pend) begin
      rec_cnt  <= sat_inc(rec_cnt);
    end
  end

  // address-to-address cycle time
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_age <= '1;
      wrote   <= 1'b0;
    end else if (addr_chg) begin
      cyc_age <= ONE;
      wrote   <= win_now;
    end else begin
      cyc_age <= sat_inc(cyc_age);
      wrote   <= wrote | win_now;
    end
  end

  // R2: an address-hold error needs the window open on the previous sample too
  a_r2_hold_needs_prior_window: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_ADDR_HOLD] |-> $past(win_now));

  // R4: a pulse-width error only follows a low write-enable sample
  a_r4_width_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_WE_WIDTH] |-> $past(we_low));

  // R5: any address change retires the pending recovery check
  a_r5_rec_retired: assert property (@(posedge clk) disable iff (!rst_n)
    addr_chg |=> !rec_pend);

  // R6: each address change restarts the cycle measurement
  a_r6_cycle_restart: assert property (@(posedge clk) disable iff (!rst_n)
    addr_chg |=> (cyc_age == ONE));

  // R3: a data-setup error only at a window close
  a_r3_setup_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    viol[RULE_DATA_SETUP] |-> $past(win_now) && !win_now);

endmodule

// File: rtl/wchk_log.sv
module wchk_log
  import sram_wchk_pkg::*;
#(
  parameter int VCNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [NUM_RULES-1:0] viol,
  output logic [NUM_RULES-1:0] err_flags,
  output logic                 evt_valid,
  output logic [CODE_W-1:0]    evt_code,
  output logic [VCNT_W-1:0]    viol_cnt
);

  localparam int SUM_W = VCNT_W + 3;
  localparam logic [VCNT_W-1:0] CNT_MAX = '1;

  logic [CODE_W-1:0] first_code;
  logic [SUM_W-1:0]  add_n;
  logic [SUM_W-1:0]  base;
  logic [SUM_W-1:0]  sum;
  logic [VCNT_W-1:0] next_cnt;

  always_comb begin
    first_code = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (viol[i]) first_code = CODE_W'(i);
    end
    add_n    = SUM_W'($countones(viol[NUM_VIOL-1:0]));
    base     = clr ? '0 : SUM_W'(viol_cnt);
    sum      = base + add_n;
    next_cnt = (sum > SUM_W'(CNT_MAX)) ? CNT_MAX : sum[VCNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flags <= '0;
      evt_valid <= 1'b0;
      evt_code  <= '0;
      viol_cnt  <= '0;
    end else begin
      err_flags <= clr ? viol : (err_flags | viol);
      evt_valid <= |viol;
      evt_code  <= first_code;
      viol_cnt  <= next_cnt;
    end
  end

  // R8: the reported code always has its sticky flag set
  a_r8_code_flagged: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> err_flags[evt_code]);

  // R10: a full counter stays full until cleared
  a_r10_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_cnt == CNT_MAX && !clr) |=> (viol_cnt == CNT_MAX));

  // R7: a sample with no timing violation leaves the count unchanged
  a_r7_contention_uncounted: assert property (@(posedge clk) disable iff (!rst_n)
    (viol[NUM_VIOL-1:0] == '0 && !clr) |=> $stable(viol_cnt));

  // R9: flags hold without a clear
  for (genvar g = 0; g < NUM_RULES; g++) begin : g_sticky
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flags[g] && !clr) |=> err_flags[g]);
  end

endmodule

// File: rtl/sram_wr_timing_mon.sv
module sram_wr_timing_mon
  import sram_wchk_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int TICK_PS   = 5000,
  parameter int T_WC_NS   = 70,
  parameter int T_WP_NS   = 55,
  parameter int T_DSU_NS  = 30,
  parameter int T_WR1_NS  = 5,
  parameter int T_WR2_NS  = 15,
  parameter int VCNT_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              host_drv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              clr,
  output logic [5:0]        err_flags,
  output logic              evt_valid,
  output logic [2:0]        evt_code,
  output logic [VCNT_W-1:0] viol_cnt
);

  localparam int WC_T  = ns_to_ticks(T_WC_NS,  TICK_PS);
  localparam int WP_T  = ns_to_ticks(T_WP_NS,  TICK_PS);
  localparam int DSU_T = ns_to_ticks(T_DSU_NS, TICK_PS);
  localparam int WR1_T = ns_to_ticks(T_WR1_NS, TICK_PS);
  localparam int WR2_T = ns_to_ticks(T_WR2_NS, TICK_PS);
  localparam int MAX_T = max_of2(max_of2(WC_T, WP_T),
                                 max_of2(DSU_T, max_of2(WR1_T, WR2_T)));
  localparam int CNT_W = ctr_width(MAX_T);

  logic                 win_now;
  logic                 win_open;
  logic                 win_close;
  logic                 close_by_we;
  logic                 we_low;
  logic                 we_rise;
  logic                 addr_chg;
  logic                 data_chg;
  logic                 contend_onset;
  logic [NUM_RULES-1:0] viol;

  wchk_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sampler (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .host_drv(host_drv), .addr(addr), .din(din),
    .win_now(win_now), .win_open(win_open), .win_close(win_close),
    .close_by_we(close_by_we), .we_low(we_low), .we_rise(we_rise),
    .addr_chg(addr_chg), .data_chg(data_chg), .contend_onset(contend_onset)
  );

  wchk_rules #(
    .CNT_W(CNT_W), .WC_T(WC_T), .WP_T(WP_T), .DSU_T(DSU_T),
    .WR1_T(WR1_T), .WR2_T(WR2_T)
  ) u_rules (
    .clk(clk), .rst_n(rst_n), .win_now(win_now), .win_open(win_open),
    .win_close(win_close), .close_by_we(close_by_we), .we_low(we_low),
    .we_rise(we_rise), .addr_chg(addr_chg), .data_chg(data_chg),
    .contend_onset(contend_onset), .viol(viol)
  );

  wchk_log #(.VCNT_W(VCNT_W)) u_log (
    .clk(clk), .rst_n(rst_n), .clr(clr), .viol(viol),
    .err_flags(err_flags), .evt_valid(evt_valid), .evt_code(evt_code),
    .viol_cnt(viol_cnt)
  );

  // R11: outputs are quiet on the first cycle out of reset
  a_r11_reset_quiet: assert property (@(posedge clk)
    $rose(rst_n) |-> (err_flags == '0 && !evt_valid && viol_cnt == '0));

  // R8: an event pulse lasts one cycle unless a rule fires again
  a_r8_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $past(|viol));

endmodule

// File: tb/sram_wr_timing_mon_tb.sv
module sram_wr_timing_mon_tb_top;

  localparam int CLK_P   = 10;
  localparam int AW      = 8;
  localparam int DW      = 8;
  localparam int TPS     = 10000;
  localparam int NS_WC   = 100;
  localparam int NS_WP   = 55;
  localparam int NS_DSU  = 30;
  localparam int NS_WR1  = 5;
  localparam int NS_WR2  = 15;
  localparam int CW      = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, host_drv = 1'b0, clr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [5:0]    err_flags;
  logic          evt_valid;
  logic [2:0]    evt_code;
  logic [CW-1:0] viol_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  sram_wr_timing_mon #(
    .ADDR_W(AW), .DATA_W(DW), .TICK_PS(TPS), .T_WC_NS(NS_WC), .T_WP_NS(NS_WP),
    .T_DSU_NS(NS_DSU), .T_WR1_NS(NS_WR1), .T_WR2_NS(NS_WR2), .VCNT_W(CW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .host_drv(host_drv), .addr(addr), .din(din), .clr(clr),
    .err_flags(err_flags), .evt_valid(evt_valid), .evt_code(evt_code),
    .viol_cnt(viol_cnt)
  );

  // R12: tick count as the first multiple of the period reaching the minimum
  function automatic int ticks_for(input int ns);
    int k = 1;
    while (k * TPS < ns * 1000) k++;
    return k;
  endfunction

  int lim_wc, lim_wp, lim_dsu, lim_wr1, lim_wr2;
  initial begin
    lim_wc  = ticks_for(NS_WC);
    lim_wp  = ticks_for(NS_WP);
    lim_dsu = ticks_for(NS_DSU);
    lim_wr1 = ticks_for(NS_WR1);
    lim_wr2 = ticks_for(NS_WR2);
  end

  // behavioural reference model, time-stamp based
  int  n, last_d, last_a, rec_t, rec_lim, run;
  bit  pwin, pwe, pc, pend, wrote;
  logic [AW-1:0] pa;
  logic [DW-1:0] pd;
  int  e_flags, e_valid, e_code, e_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      n = 0; last_d = -1000; last_a = -1000; rec_t = 0; rec_lim = 1; run = 0;
      pwin = 0; pwe = 1; pc = 0; pend = 0; wrote = 0; pa = '0; pd = '0;
      e_flags = 0; e_valid = 0; e_code = 0; e_cnt = 0;
    end else begin
      bit win, ca, close, cont;
      bit v[6];
      int nv;
      n++;
      foreach (v[i]) v[i] = 0;
      win   = !ce_n && !we_n;
      ca    = (addr !== pa);
      close = pwin && !win;
      if (ca && pwin && win) v[0] = 1;
      if (close && (n - 1 - last_d) < lim_dsu) v[1] = 1;
      if (din !== pd) last_d = n;
      if (we_n && !pwe && run < lim_wp) v[2] = 1;
      run = !we_n ? run + 1 : 0;
      if (ca && (close || (pend && (n - rec_t) < rec_lim))) v[3] = 1;
      if (close && !ca) begin pend = 1; rec_t = n; rec_lim = we_n ? lim_wr1 : lim_wr2; end
      else if (ca || (win && !pwin)) pend = 0;
      if (ca) begin
        if (wrote && (n - last_a) < lim_wc) v[4] = 1;
        last_a = n; wrote = win;
      end else wrote = wrote || win;
      cont = win && !oe_n && host_drv;
      if (cont && !pc) v[5] = 1;
      pc = cont;
      nv = v[0] + v[1] + v[2] + v[3] + v[4];
      if (clr) begin e_flags = 0; e_cnt = 0; end
      e_valid = 0; e_code = 0;
      for (int i = 5; i >= 0; i--) if (v[i]) begin e_valid = 1; e_code = i; e_flags |= (1 << i); end
      e_cnt = e_cnt + nv;
      if (e_cnt > (1 << CW) - 1) e_cnt = (1 << CW) - 1;
      pa = addr; pd = din; pwe = we_n; pwin = win;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R8 flags vs model", int'(err_flags), e_flags);
      check("R8 valid vs model", int'(evt_valid), e_valid);
      if (e_valid != 0) check("R8 code vs model", int'(evt_code), e_code);
      check("R10 count vs model", int'(viol_cnt), e_cnt);
    end
  end

  task automatic step(input int k);
    repeat (k) @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic do_clear();
    clr = 1'b1; step(1);
    clr = 1'b0; step(1);
    check("R9 cleared flags", int'(err_flags), 0);
    check("R9 cleared count", int'(viol_cnt), 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1; step(1);
    check("R11 reset flags", int'(err_flags), 0);
    check("R11 reset valid", int'(evt_valid), 0);
    check("R11 reset count", int'(viol_cnt), 0);
    check("R12 tick rounding", lim_wp * 10 + lim_wr2, 62);

    // clean write, write pulse exactly at the limit
    addr = 8'd1; din = 8'd11; step(1);
    ce_n = 0; step(1);
    we_n = 0; step(6);
    we_n = 1; step(1);
    ce_n = 1; step(10);
    addr = 8'd2; step(1);
    check("R1 clean write", int'(err_flags), 0);
    check("R12 width at limit passes", int'(err_flags[2]), 0);

    // address moves inside the window
    ce_n = 0; we_n = 0; step(3);
    addr = 8'd3; step(3);
    we_n = 1; ce_n = 1; step(12);
    check("R2 address hold", int'(err_flags[0]), 1);
    do_clear();

    // data changes one sample before close
    addr = 8'd4; step(12);
    ce_n = 0; we_n = 0; din = 8'd22; step(5);
    din = 8'd33; step(1);
    we_n = 1; ce_n = 1; step(12);
    check("R3 data setup", int'(err_flags[1]), 1);
    do_clear();

    // write pulse one sample short
    addr = 8'd5; step(12);
    ce_n = 0; we_n = 0; step(5);
    we_n = 1; ce_n = 1; step(12);
    check("R4 short pulse", int'(err_flags[2]), 1);
    do_clear();

    // chip-enable ended write, address one tick later
    addr = 8'd6; step(12);
    ce_n = 0; we_n = 0; step(7);
    ce_n = 1; step(1);
    addr = 8'd7; step(1);
    check("R8 event pulse", int'(evt_valid), 1);
    check("R8 lowest code", int'(evt_code), 3);
    we_n = 1; step(12);
    check("R5 long recovery miss", int'(err_flags[3]), 1);
    do_clear();

    // write-enable ended write, one tick is enough
    addr = 8'd8; step(12);
    ce_n = 0; we_n = 0; step(7);
    we_n = 1; step(1);
    addr = 8'd9; step(1);
    ce_n = 1; step(12);
    check("R5 short recovery met", int'(err_flags[3]), 0);

    // chip-enable ended write, two ticks met
    addr = 8'd20; step(12);
    ce_n = 0; we_n = 0; step(7);
    ce_n = 1; step(2);
    addr = 8'd21; we_n = 1; step(12);
    check("R5 long recovery met", int'(err_flags[3]), 0);
    do_clear();

    // cycle too short, other rules met, both enables rise together
    addr = 8'd10; ce_n = 0; we_n = 0; step(6);
    we_n = 1; ce_n = 1; step(1);
    addr = 8'd11; step(12);
    check("R6 cycle time", int'(err_flags[4]), 1);
    check("R5 joint rise uses short rule", int'(err_flags[3]), 0);
    do_clear();

    // contention warning, not counted
    addr = 8'd12; step(12);
    ce_n = 0; we_n = 0; oe_n = 0; host_drv = 1; step(7);
    ce_n = 1; we_n = 1; oe_n = 1; host_drv = 0; step(12);
    check("R7 contention flag", int'(err_flags[5]), 1);
    check("R7 not counted", int'(viol_cnt), 0);
    do_clear();

    // saturation
    addr = 8'd13; step(12);
    ce_n = 0; we_n = 0; step(1);
    for (int i = 0; i < 10; i++) begin
      addr = addr + 8'd1; step(1);
    end
    we_n = 1; ce_n = 1; step(12);
    check("R10 saturated", int'(viol_cnt), 7);

    // event on the same sample as clear
    ce_n = 0; we_n = 0; step(2);
    addr = addr + 8'd1; clr = 1'b1; step(1);
    clr = 1'b0; step(1);
    check("R9 event beats clear flags", int'(err_flags), 1);
    check("R9 event beats clear count", int'(viol_cnt), 1);
    we_n = 1; ce_n = 1; step(12);

    finish_run();
  end

endmodule